// File: doc/BRIEF.md
# Priority interrupt controller

This block gathers eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt line to the processor. The processor answers with a pair of acknowledge pulses. On the first pulse the controller moves the winning request into service. On the second pulse it drives an 8-bit vector onto the read data bus. That vector joins a programmable base with the number of the level being served.

Software talks to the controller through two byte-wide addresses chosen by `a0`. An ordered sequence of setup words fixes four things: edge or level sensing, the vector base, whether a cascade word and a fourth word follow, and whether end-of-interrupt is automatic. Once setup is complete, a write to the odd address loads the mask. Writes to the even address are sorted by data bits 4:3 into end-of-interrupt commands and read-select commands. Each line that is in service blocks lines of equal or lower rank until software, or the automatic mode, clears it.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, and until the setup sequence is complete, `int_out` stays low whatever the request lines do.
- R2: A write to the even address with data bit 4 set starts setup. It clears the mask and in-service registers. Its bit 3 selects level (1) or edge (0) sensing, bit 1 selects single (1) or cascaded (0) mode, and bit 0 says a fourth word follows.
- R3: The next odd-address write supplies vector bits 7:3. One more odd write is consumed only in cascaded mode, and one more only if a fourth word was requested. After that, the controller is ready.
- R4: Once the controller is ready, an odd-address write loads the mask, where bit n = 1 disables line n. An odd-address read returns the mask.
- R5: In edge mode a request bit is set by a rising edge on its line. It stays set after the line falls, until the first acknowledge pulse takes it.
- R6: In level mode a request bit follows its line.
- R7: Priority is fixed, with line 0 highest and line 7 lowest. `int_out` is high exactly when the controller is ready and some unmasked request has a lower index than every set in-service bit.
- R8: The first `ack` pulse sets the in-service bit of the highest-priority unmasked request and clears its request bit. If nothing is pending, no in-service bit is set and level 7 is reported.
- R9: While the second `ack` pulse is high, `rdata` = {vector bits 7:3, level}.
- R10: An even-address write with bits 4:3 = 00 is an end-of-interrupt command, selected by bits 7:5. 001 clears the highest-priority set in-service bit, 011 clears the bit numbered by bits 2:0, and 010 changes nothing.
- R11: An even-address write with bits 4:3 = 01 and bit 1 set makes later even-address reads return the request register (bit 0 = 1) or the in-service register (bit 0 = 0). With bit 1 clear the selection is kept. Setup selects the request register.
- R12: When bit 1 of the fourth word is set, the in-service bit is cleared at the end of the second acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| a0 | input | 1 | Address select: 0 even, 1 odd |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, or the vector during the second acknowledge |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
The bench nests a higher-priority request on top of one already in service. A design that compared ranks the wrong way would either hold back the nested request or let a lower one interrupt. It walks each branch of the setup sequence, cascaded with a fourth word and single without one. A miscounted sequence would load the mask from a setup word. It also covers an edge request whose line falls before it is acknowledged, a masked request that is still visible in the request register, an acknowledge with nothing pending, which must report level 7, and automatic end-of-interrupt with a level still asserted, which must raise the interrupt again right away. Specific, non-specific and no-op end-of-interrupt commands are each checked against the in-service register read back through the port.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int LVL_W  = 3;
    localparam int N_IRQ  = 1 << LVL_W;
    localparam int DW     = 8;
    localparam int BASE_W = DW - LVL_W;

    localparam logic [2:0] EOI_NONSPEC = 3'b001;
    localparam logic [2:0] EOI_SPEC    = 3'b011;

    typedef enum logic [2:0] {
        S_UNINIT,
        S_W2,
        S_W3,
        S_W4,
        S_READY
    } init_st_t;

    typedef struct packed {
        logic              ready;
        logic              level_mode;
        logic              auto_eoi;
        logic              rd_irr;
        logic [BASE_W-1:0] base;
    } cfg_t;

    typedef struct packed {
        logic             hit;
        logic [LVL_W-1:0] idx;
    } pick_t;

    // Lowest set index wins; with no bit set the index reads all ones.
    function automatic pick_t pick_first(input logic [N_IRQ-1:0] v);
        pick_t p;
        p.hit = 1'b0;
        p.idx = '1;
        for (int i = N_IRQ - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = LVL_W'(i);
            end
        end
        return p;
    endfunction
endpackage

// File: rtl/irq_ctrl_regif.sv
module irq_ctrl_regif
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             a0,
    input  logic [DW-1:0]    wdata,
    output cfg_t             cfg,
    output logic [N_IRQ-1:0] mask,
    output logic             init_pulse,
    output logic             eoi_valid,
    output logic [2:0]       eoi_cmd,
    output logic [LVL_W-1:0] eoi_lvl
);
    init_st_t          st;
    logic              need_w4;
    logic              single;
    logic              lvl_q;
    logic              aeoi_q;
    logic              rdirr_q;
    logic [BASE_W-1:0] base_q;

    logic is_w1, is_cmd, is_sel, odd_wr;

    always_comb begin
        is_w1   = wr_en && !a0 && wdata[4];
        is_cmd  = wr_en && !a0 && (wdata[4:3] == 2'b00) && (st == S_READY);
        is_sel  = wr_en && !a0 && (wdata[4:3] == 2'b01) && (st == S_READY);
        odd_wr  = wr_en && a0;
        init_pulse = is_w1;
        eoi_valid  = is_cmd;
        eoi_cmd    = wdata[7:5];
        eoi_lvl    = wdata[LVL_W-1:0];
        cfg.ready      = (st == S_READY);
        cfg.level_mode = lvl_q;
        cfg.auto_eoi   = aeoi_q;
        cfg.rd_irr     = rdirr_q;
        cfg.base       = base_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_UNINIT;
            need_w4 <= 1'b0;
            single  <= 1'b0;
            lvl_q   <= 1'b0;
            aeoi_q  <= 1'b0;
            rdirr_q <= 1'b1;
            base_q  <= '0;
            mask    <= '0;
        end else if (is_w1) begin
            st      <= S_W2;
            need_w4 <= wdata[0];
            single  <= wdata[1];
            lvl_q   <= wdata[3];
            aeoi_q  <= 1'b0;
            rdirr_q <= 1'b1;
            mask    <= '0;
        end else if (odd_wr) begin
            case (st)
                S_W2: begin
                    base_q <= wdata[DW-1:LVL_W];
                    if (!single)      st <= S_W3;
                    else if (need_w4) st <= S_W4;
                    else              st <= S_READY;
                end
                S_W3: st <= need_w4 ? S_W4 : S_READY;
                S_W4: begin
                    aeoi_q <= wdata[1];
                    st     <= S_READY;
                end
                S_READY: mask <= wdata;
                default: ;
            endcase
        end else if (is_sel && wdata[1]) begin
            rdirr_q <= wdata[0];
        end
    end
endmodule

// File: rtl/irq_ctrl_capture.sv
module irq_ctrl_capture
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] irq_in,
    input  logic             level_mode,
    input  logic             init_pulse,
    input  logic [N_IRQ-1:0] clr,
    output logic [N_IRQ-1:0] irr
);
    logic [N_IRQ-1:0] prev;

    for (genvar g = 0; g < N_IRQ; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                prev[g] <= 1'b0;
                irr[g]  <= 1'b0;
            end else begin
                prev[g] <= irq_in[g];
                if (init_pulse)                  irr[g] <= 1'b0;
                else if (level_mode)             irr[g] <= irq_in[g];
                else if (irq_in[g] && !prev[g])  irr[g] <= 1'b1;
                else if (clr[g])                 irr[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_ctrl_service.sv
module irq_ctrl_service
    import irq_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ready,
    input  logic              auto_eoi,
    input  logic [BASE_W-1:0] base,
    input  logic [N_IRQ-1:0]  irr,
    input  logic [N_IRQ-1:0]  mask,
    input  logic              ack,
    input  logic              init_pulse,
    input  logic              eoi_valid,
    input  logic [2:0]        eoi_cmd,
    input  logic [LVL_W-1:0]  eoi_lvl,
    output logic [N_IRQ-1:0]  isr,
    output logic [N_IRQ-1:0]  ack_clr,
    output logic              int_out,
    output logic              vec_drive,
    output logic [DW-1:0]     vec,
    output logic              phase,
    output logic [LVL_W-1:0]  lvl_q
);
    logic             took_q;
    pick_t            pp, ip;
    logic             ack_first, ack_second;
    logic [N_IRQ-1:0] isr_next;

    always_comb begin
        pp = pick_first(irr & ~mask);
        ip = pick_first(isr);
        int_out    = ready && pp.hit && (!ip.hit || (pp.idx < ip.idx));
        ack_first  = ack && !phase;
        ack_second = ack && phase;
        ack_clr    = (ack_first && pp.hit) ? (N_IRQ'(1) << pp.idx) : '0;
        vec_drive  = ack_second;
        vec        = {base, lvl_q};

        isr_next = isr;
        if (ack_first && pp.hit)
            isr_next[pp.idx] = 1'b1;
        if (ack_second && auto_eoi && took_q)
            isr_next[lvl_q] = 1'b0;
        if (eoi_valid) begin
            case (eoi_cmd)
                EOI_NONSPEC: if (ip.hit) isr_next[ip.idx] = 1'b0;
                EOI_SPEC:    isr_next[eoi_lvl] = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr    <= '0;
            phase  <= 1'b0;
            lvl_q  <= '1;
            took_q <= 1'b0;
        end else if (init_pulse) begin
            isr    <= '0;
            phase  <= 1'b0;
            took_q <= 1'b0;
        end else begin
            isr <= isr_next;
            if (ack_first) begin
                phase  <= 1'b1;
                lvl_q  <= pp.idx;
                took_q <= pp.hit;
            end else if (ack_second) begin
                phase  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          a0,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic [7:0]    irq_in,
    input  logic          ack,
    output logic          int_out
);
    cfg_t             cfg_w;
    logic [N_IRQ-1:0] mask_w, irr_w, isr_w, clr_w;
    logic             init_w, eoi_v_w, vdrv_w, phase_w;
    logic [2:0]       eoi_c_w;
    logic [LVL_W-1:0] eoi_l_w, lvl_w;
    logic [DW-1:0]    vec_w;

    irq_ctrl_regif u_regif (
        .clk(clk), .rst(rst), .wr_en(wr_en), .a0(a0), .wdata(wdata),
        .cfg(cfg_w), .mask(mask_w), .init_pulse(init_w),
        .eoi_valid(eoi_v_w), .eoi_cmd(eoi_c_w), .eoi_lvl(eoi_l_w)
    );

    irq_ctrl_capture u_capture (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level_mode(cfg_w.level_mode),
        .init_pulse(init_w), .clr(clr_w), .irr(irr_w)
    );

    irq_ctrl_service u_service (
        .clk(clk), .rst(rst), .ready(cfg_w.ready), .auto_eoi(cfg_w.auto_eoi),
        .base(cfg_w.base), .irr(irr_w), .mask(mask_w), .ack(ack),
        .init_pulse(init_w), .eoi_valid(eoi_v_w), .eoi_cmd(eoi_c_w),
        .eoi_lvl(eoi_l_w), .isr(isr_w), .ack_clr(clr_w), .int_out(int_out),
        .vec_drive(vdrv_w), .vec(vec_w), .phase(phase_w), .lvl_q(lvl_w)
    );

    always_comb begin
        if (vdrv_w)      rdata = vec_w;
        else if (!rd_en) rdata = '0;
        else if (a0)     rdata = mask_w;
        else             rdata = cfg_w.rd_irr ? irr_w : isr_w;
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       a0,
    input logic [7:0] wdata,
    input logic       ack,
    input logic       int_out,
    input logic [7:0] irr,
    input logic [7:0] isr,
    input logic [7:0] mask,
    input logic       ready,
    input logic       level_mode,
    input logic       auto_eoi,
    input logic       phase
);
    // R1
    no_early_int_chk: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !int_out);

    // R7
    int_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        int_out |-> ((irr & ~mask) != 8'h00));

    // R2
    setup_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !a0 && wdata[4]) |=> (isr == 8'h00 && mask == 8'h00));

    // R4
    mask_keeps_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && a0 && !ack) |=> $stable(isr));

    // R8
    ack_sets_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && !phase && !wr_en && ((irr & ~mask) != 8'h00)) |=> (isr != 8'h00));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !level_mode && !ack && !wr_en) |=> ((irr & $past(irr)) == $past(irr)));

    // R10
    nonspec_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && wr_en && !a0 && wdata[7:3] == 5'b00100 && isr != 8'h00 && !ack)
        |=> ($countones(isr) + 1 == $countones($past(isr))));

    // R12
    auto_eoi_chk: assert property (@(posedge clk) disable iff (rst)
        (ack && phase && auto_eoi && !wr_en) |=> ($countones(isr) <= $countones($past(isr))));
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .a0(a0), .wdata(wdata), .ack(ack),
    .int_out(int_out), .irr(irr_w), .isr(isr_w), .mask(mask_w),
    .ready(cfg_w.ready), .level_mode(cfg_w.level_mode),
    .auto_eoi(cfg_w.auto_eoi), .phase(phase_w)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, a0 = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, irq_in = '0;
    logic [7:0] rdata;
    logic       int_out;
    int         n_chk = 0, n_err = 0;
    bit         done = 0;

    irq_ctrl dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .ack(ack), .int_out(int_out)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic addr, input logic [7:0] d);
        a0 = addr; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic addr, output logic [7:0] v);
        a0 = addr; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic ack_pair(output logic [7:0] v);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
        ack = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic read_isr(output logic [7:0] v);
        wr(1'b0, 8'h0A);
        rd(1'b0, v);
    endtask

    task automatic t_reset();
        chk("R1 int after reset", {7'b0, int_out}, 8'h00);
        set_irq(8'h01);
        set_irq(8'h00);
        set_irq(8'h01);
        chk("R1 int before setup", {7'b0, int_out}, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_edge();
        logic [7:0] v;
        wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h01);
        set_irq(8'h08);
        chk("R7 int on request", {7'b0, int_out}, 8'h01);
        set_irq(8'h00);
        chk("R5 held after fall", {7'b0, int_out}, 8'h01);
        rd(1'b0, v);
        chk("R11 default reads request reg", v, 8'h08);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk("R8 int drops after first ack", {7'b0, int_out}, 8'h00);
        ack = 1'b1; #1 v = rdata; @(negedge clk); ack = 1'b0;
        chk("R9 vector", v, 8'h43);
        read_isr(v);
        chk("R8 isr set", v, 8'h08);
        wr(1'b0, 8'h0B); rd(1'b0, v);
        chk("R8 request cleared", v, 8'h00);
        wr(1'b0, 8'h20);
        read_isr(v);
        chk("R10 non-specific clears", v, 8'h00);
    endtask

    task automatic t_prio();
        logic [7:0] v;
        set_irq(8'h24);
        chk("R7 int two pending", {7'b0, int_out}, 8'h01);
        ack_pair(v);
        chk("R9 vector level 2", v, 8'h42);
        chk("R7 lower rank blocked", {7'b0, int_out}, 8'h00);
        set_irq(8'h26);
        chk("R7 higher rank nests", {7'b0, int_out}, 8'h01);
        ack_pair(v);
        chk("R9 vector level 1", v, 8'h41);
        read_isr(v);
        chk("R8 nested isr", v, 8'h06);
        wr(1'b0, 8'h20);
        read_isr(v);
        chk("R10 non-specific takes top", v, 8'h04);
        wr(1'b0, 8'h62);
        read_isr(v);
        chk("R10 specific level 2", v, 8'h00);
        chk("R7 pending line 5 raises int", {7'b0, int_out}, 8'h01);
        ack_pair(v);
        chk("R9 vector level 5", v, 8'h45);
        wr(1'b0, 8'h40);
        read_isr(v);
        chk("R10 no-op keeps isr", v, 8'h20);
        wr(1'b0, 8'h65);
        read_isr(v);
        chk("R10 specific level 5", v, 8'h00);
        set_irq(8'h00);
    endtask

    task automatic t_mask();
        logic [7:0] v;
        wr(1'b1, 8'h01);
        set_irq(8'h01);
        chk("R4 masked line no int", {7'b0, int_out}, 8'h00);
        wr(1'b0, 8'h0B); rd(1'b0, v);
        chk("R4 masked still requested", v, 8'h01);
        rd(1'b1, v);
        chk("R4 mask readback", v, 8'h01);
        wr(1'b0, 8'h08); rd(1'b0, v);
        chk("R11 select kept without bit 1", v, 8'h01);
        wr(1'b1, 8'h00);
        chk("R4 unmasked raises int", {7'b0, int_out}, 8'h01);
        ack_pair(v);
        chk("R9 vector level 0", v, 8'h40);
        set_irq(8'h00);
        read_isr(v);
        chk("R8 isr left set", v, 8'h01);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(1'b1, 8'hF0);
        wr(1'b0, 8'h1B); wr(1'b1, 8'h80); wr(1'b1, 8'h03);
        rd(1'b1, v);
        chk("R2 setup clears mask", v, 8'h00);
        wr(1'b0, 8'h0A); rd(1'b0, v);
        chk("R2 setup clears isr", v, 8'h00);
        set_irq(8'h10);
        chk("R6 level high int", {7'b0, int_out}, 8'h01);
        set_irq(8'h00);
        chk("R6 level low no int", {7'b0, int_out}, 8'h00);
        set_irq(8'h10);
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk("R7 equal rank blocked", {7'b0, int_out}, 8'h00);
        ack = 1'b1; #1 v = rdata; @(negedge clk); ack = 1'b0;
        chk("R9 vector level 4", v, 8'h84);
        chk("R12 auto clear re-raises int", {7'b0, int_out}, 8'h01);
        rd(1'b0, v);
        chk("R12 isr empty", v, 8'h00);
        set_irq(8'h00);
        ack_pair(v);
        chk("R8 nothing pending gives level 7", v, 8'h87);
        rd(1'b0, v);
        chk("R8 no isr on empty ack", v, 8'h00);
    endtask

    task automatic t_seq();
        logic [7:0] v;
        wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h00);
        wr(1'b1, 8'h55);
        rd(1'b1, v);
        chk("R3 cascade path reaches mask", v, 8'h55);
        set_irq(8'h02);
        ack_pair(v);
        chk("R3 base from second word", v, 8'h21);
        read_isr(v);
        chk("R12 normal mode keeps isr", v, 8'h02);
        set_irq(8'h00);
        wr(1'b0, 8'h12); wr(1'b1, 8'h08);
        wr(1'b1, 8'hAA);
        rd(1'b1, v);
        chk("R3 short path reaches mask", v, 8'hAA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_edge();
        t_prio();
        t_mask();
        t_level();
        t_seq();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule